// File: doc/BRIEF.md
# Windowed Register File with Local Stack

This block holds 256 architectural general registers of 64 bits. Two limit values split the register numbers into three regions. Numbers below the local limit L are local registers. Numbers from L up to the global limit G are marginal. Numbers from G upward are global. Local registers are a sliding window onto a physical stack of 512 words. Global registers live in their own storage.

A subroutine call issues a push with a count k. The caller keeps its registers 0 to k-1 on the stack, and its register k becomes a link slot that records k. The caller's registers above k become the callee's registers 0 and upward. A return issues a pop, which reads the link slot, moves the window back and restores the caller's registers.

Two read ports are combinational. The write port and all commands take effect at the clock edge. When a command would take the stack past its depth or below its bottom, the block raises a request flag for that cycle and does nothing. Moving words to and from memory is left to the logic outside the block.

Top module: `winreg_file`

## Requirements
- R1: After reset L is 0, G is 255, the window base is 0, both request flags are low, and every register reads zero.
- R2: A register number r below L maps to stack word base+r. A write to it is returned by later reads of r.
- R3: A read of a register number r with L <= r < G returns zero.
- R4: A write to a marginal number r sets L to r+1 at the edge and stores the data as register r.
- R5: Register numbers at or above G read and write a separate global store. Push, pop and changes of L leave that store untouched.
- R6: A push with count k that does not overflow writes k into stack word base+k and adds k+1 to the base. It sets L to L-k-1 when L > k, and to 0 otherwise. The callee's register j is then the caller's register k+1+j.
- R7: A pop at a nonzero base reads the count k from stack word base-1. It moves the base to base-1-k and sets L to the smaller of k and G. The caller's registers 0 to k-1 read their values from before the push.
- R8: spill_req is high, and L, G, the base and all storage are unchanged, when one of these would make base+L exceed 512: a push, an L write that raises L, or a write to a marginal register.
- R9: fill_req is high, and the state is unchanged, when a pop arrives while the base is 0.
- R10: A stack word that enters the local window through a growth of L, or that a push puts below the link slot beyond the old L, reads zero until it is written.
- R11: A G write stores the larger of the value and 32, and pulls L down to the new G if L exceeds it. An L write stores the smaller of the value and G.
- R12: A read whose number equals that of a write performed in the same cycle returns the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 8 | Read port A register number |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 8 | Read port B register number |
| rb_data | output | 64 | Read port B data |
| we | input | 1 | Register write enable |
| wa_idx | input | 8 | Register write number |
| wd | input | 64 | Register write data |
| push | input | 1 | Push command |
| push_cnt | input | 8 | Number of caller registers kept by a push |
| pop | input | 1 | Pop command |
| l_we | input | 1 | Write the local limit |
| l_wdata | input | 8 | New local limit |
| g_we | input | 1 | Write the global limit |
| g_wdata | input | 8 | New global limit |
| l_val | output | 8 | Current local limit L |
| g_val | output | 8 | Current global limit G |
| win_base | output | 10 | Current window base on the physical stack |
| spill_req | output | 1 | The present command would overflow the stack and is held |
| fill_req | output | 1 | The present pop would underflow the stack and is held |

## Verification
The properties assume that at most one of we, push, pop, l_we and g_we is high in any cycle. They do not cover the order in which commands win when several arrive together. The stimulus issues exactly one command, or none, in each cycle. Under that rule the random mix reaches marginal growth, nested pushes and pops, limit changes and both request flags. A directed stretch drives the base to the top of the stack, and another pops at the bottom.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int W     = 64,
  parameter int NREG  = 256,
  parameter int DEPTH = 512,
  parameter int GMIN  = 32,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa_idx,
  input  logic [W-1:0]  wd,
  input  logic          push,
  input  logic [AW-1:0] push_cnt,
  input  logic          pop,
  input  logic          l_we,
  input  logic [AW-1:0] l_wdata,
  input  logic          g_we,
  input  logic [AW-1:0] g_wdata,
  output logic [AW-1:0] l_val,
  output logic [AW-1:0] g_val,
  output logic [BW-1:0] win_base,
  output logic          spill_req,
  output logic          fill_req
);
  localparam logic [BW:0]   CAP   = (BW+1)'(DEPTH);
  localparam logic [AW-1:0] GLO   = AW'(GMIN);
  localparam logic [AW-1:0] GTOP  = AW'(NREG - 1);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [BW-1:0] ONE_B = BW'(1);
  localparam logic [BW:0]   ONE_X = (BW+1)'(1);

  logic [W-1:0]     stk [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     glb [NREG];
  logic [NREG-1:0]  gvld;

  logic [AW-1:0] lr, gr, nL, nG, nl, mk;
  logic [BW-1:0] br, nB, stk_wa, pop_idx;
  logic [BW:0]   base_x, top, clr_lo, clr_hi;
  logic [W-1:0]  stk_wd;
  logic          stk_we, glb_we, wr_ok, spill, fill;

  assign base_x  = {1'b0, br};
  assign pop_idx = (br == '0) ? '0 : br - ONE_B;
  assign mk      = stk[pop_idx][AW-1:0];

  always_comb begin
    nL = lr; nG = gr; nB = br; nl = '0; top = '0;
    clr_lo = '0; clr_hi = '0;
    stk_we = 1'b0; stk_wa = br; stk_wd = wd;
    glb_we = 1'b0; wr_ok = 1'b0; spill = 1'b0; fill = 1'b0;
    if (push) begin
      nl  = (lr > push_cnt) ? lr - push_cnt - ONE_A : '0;
      top = base_x + (BW+1)'(push_cnt) + (BW+1)'(nl) + ONE_X;
      if (top > CAP) spill = 1'b1;
      else begin
        clr_lo = base_x + (BW+1)'(lr);
        clr_hi = base_x + (BW+1)'(push_cnt);
        stk_we = 1'b1;
        stk_wa = br + BW'(push_cnt);
        stk_wd = W'(push_cnt);
        nB     = br + BW'(push_cnt) + ONE_B;
        nL     = nl;
      end
    end else if (pop) begin
      if (br == '0) fill = 1'b1;
      else begin
        nB = pop_idx - BW'(mk);
        nL = (mk < gr) ? mk : gr;
      end
    end else if (l_we) begin
      nl  = (l_wdata < gr) ? l_wdata : gr;
      top = base_x + (BW+1)'(nl);
      if (nl > lr && top > CAP) spill = 1'b1;
      else begin
        clr_lo = base_x + (BW+1)'(lr);
        clr_hi = top;
        nL     = nl;
      end
    end else if (g_we) begin
      nG = (g_wdata < GLO) ? GLO : g_wdata;
      nL = (lr > nG) ? nG : lr;
    end else if (we) begin
      if (wa_idx >= gr) begin
        glb_we = 1'b1;
        wr_ok  = 1'b1;
      end else begin
        top = base_x + (BW+1)'(wa_idx) + ONE_X;
        if (wa_idx >= lr && top > CAP) spill = 1'b1;
        else begin
          wr_ok  = 1'b1;
          stk_we = 1'b1;
          stk_wa = br + BW'(wa_idx);
          if (wa_idx >= lr) begin
            clr_lo = base_x + (BW+1)'(lr);
            clr_hi = base_x + (BW+1)'(wa_idx);
            nL     = wa_idx + ONE_A;
          end
        end
      end
    end
  end

  function automatic logic [W-1:0] fetch(input logic [AW-1:0] idx);
    logic [BW-1:0] p;
    p = br + BW'(idx);
    if (idx < lr)      return vld[p] ? stk[p] : '0;
    else if (idx < gr) return '0;
    else               return gvld[idx] ? glb[idx] : '0;
  endfunction

  assign ra_data   = (wr_ok && wa_idx == ra_idx) ? wd : fetch(ra_idx);
  assign rb_data   = (wr_ok && wa_idx == rb_idx) ? wd : fetch(rb_idx);
  assign l_val     = lr;
  assign g_val     = gr;
  assign win_base  = br;
  assign spill_req = spill;
  assign fill_req  = fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr <= '0; gr <= GTOP; br <= '0; vld <= '0; gvld <= '0;
    end else begin
      lr <= nL; gr <= nG; br <= nB;
      for (int i = 0; i < DEPTH; i++)
        if ((BW+1)'(i) >= clr_lo && (BW+1)'(i) < clr_hi) vld[i] <= 1'b0;
      if (stk_we) vld[stk_wa] <= 1'b1;
      if (glb_we) gvld[wa_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stk_we) stk[stk_wa] <= stk_wd;
    if (glb_we) glb[wa_idx] <= wd;
  end
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int W    = 64,
  parameter int AW   = 8,
  parameter int BW   = 10,
  parameter int GMIN = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ra_idx,
  input logic [W-1:0]  ra_data,
  input logic          we,
  input logic [AW-1:0] wa_idx,
  input logic [W-1:0]  wd,
  input logic          push,
  input logic [AW-1:0] push_cnt,
  input logic          pop,
  input logic          l_we,
  input logic          g_we,
  input logic [AW-1:0] l_val,
  input logic [AW-1:0] g_val,
  input logic [BW-1:0] win_base,
  input logic          spill_req,
  input logic          fill_req
);
  logic only_we;
  assign only_we = we && !push && !pop && !l_we && !g_we;

  a_r11_l_within_g: assert property (@(posedge clk) disable iff (!rst_n)
    l_val <= g_val);
  a_r11_g_floor: assert property (@(posedge clk) disable iff (!rst_n)
    g_val >= AW'(GMIN));
  a_r8_spill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |=> $stable(win_base) && $stable(l_val));
  a_r9_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> $stable(win_base) && $stable(l_val));
  a_r9_fill_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> win_base == '0);
  a_r3_marginal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx >= l_val && ra_idx < g_val && !(we && wa_idx == ra_idx)) |-> ra_data == '0);
  a_r4_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (only_we && !spill_req && wa_idx >= l_val && wa_idx < g_val)
      |=> l_val == $past(wa_idx) + AW'(1));
  a_r6_push_base: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !spill_req) |=> win_base == $past(win_base) + BW'($past(push_cnt)) + BW'(1));
  a_r12_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (only_we && !spill_req && ra_idx == wa_idx) |-> ra_data == wd);
endmodule

bind winreg_file winreg_chk #(.W(W), .AW(AW), .BW(BW), .GMIN(GMIN)) u_chk (.*);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [7:0]  ra_idx, rb_idx, wa_idx, push_cnt, l_wdata, g_wdata;
  logic [63:0] ra_data, rb_data, wd;
  logic        we, push, pop, l_we, g_we;
  logic [7:0]  l_val, g_val;
  logic [9:0]  win_base;
  logic        spill_req, fill_req;

  winreg_file u0 (.*);

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  logic [63:0] mstk [DEPTH];
  bit          mv   [DEPTH];
  logic [63:0] mglb [256];
  bit          mgv  [256];
  int mL, mG, mbase;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mrd(input int idx);
    if (idx < mL)      return mv[mbase+idx] ? mstk[mbase+idx] : 64'd0;
    else if (idx < mG) return 64'd0;
    else               return mgv[idx] ? mglb[idx] : 64'd0;
  endfunction

  function automatic string rtag(input int idx);
    if (idx < mL)      return mv[mbase+idx] ? "R2" : "R10";
    else if (idx < mG) return "R3";
    else               return "R5";
  endfunction

  task automatic mstep(input int op, input int a, input logic [63:0] d,
                       input bit commit, output bit sp, output bit fl);
    int nl, m;
    sp = 1'b0; fl = 1'b0;
    case (op)
      1: if (a < mL) begin
           if (commit) begin mstk[mbase+a] = d; mv[mbase+a] = 1'b1; end
         end else if (a < mG) begin
           if (mbase + a + 1 > DEPTH) sp = 1'b1;
           else if (commit) begin
             for (int i = mbase + mL; i < mbase + a; i++) mv[i] = 1'b0;
             mstk[mbase+a] = d; mv[mbase+a] = 1'b1; mL = a + 1;
           end
         end else if (commit) begin mglb[a] = d; mgv[a] = 1'b1; end
      2: begin
           nl = (mL > a) ? mL - a - 1 : 0;
           if (mbase + a + 1 + nl > DEPTH) sp = 1'b1;
           else if (commit) begin
             for (int i = mbase + mL; i < mbase + a; i++) mv[i] = 1'b0;
             mstk[mbase+a] = 64'(a); mv[mbase+a] = 1'b1;
             mbase = mbase + a + 1; mL = nl;
           end
         end
      3: if (mbase == 0) fl = 1'b1;
         else if (commit) begin
           m = int'(mstk[mbase-1][7:0]);
           mbase = mbase - 1 - m;
           mL = (m < mG) ? m : mG;
         end
      4: begin
           nl = (a < mG) ? a : mG;
           if (nl > mL && mbase + nl > DEPTH) sp = 1'b1;
           else if (commit) begin
             for (int i = mbase + mL; i < mbase + nl; i++) mv[i] = 1'b0;
             mL = nl;
           end
         end
      5: if (commit) begin
           mG = (a < 32) ? 32 : a;
           if (mL > mG) mL = mG;
         end
      default: ;
    endcase
  endtask

  task automatic cycle(input int op, input int a, input logic [63:0] d,
                       input int ri, input int rj);
    bit sp, fl;
    string t;
    @(negedge clk);
    we = 1'b0; push = 1'b0; pop = 1'b0; l_we = 1'b0; g_we = 1'b0;
    case (op)
      1: begin we = 1'b1; wa_idx = 8'(a); wd = d; end
      2: begin push = 1'b1; push_cnt = 8'(a); end
      3: pop = 1'b1;
      4: begin l_we = 1'b1; l_wdata = 8'(a); end
      5: begin g_we = 1'b1; g_wdata = 8'(a); end
      default: ;
    endcase
    ra_idx = 8'(ri); rb_idx = 8'(rj);
    #1;
    mstep(op, a, d, 1'b0, sp, fl);
    if (op == 1 && !sp && a == ri) chk("R12", ra_data, d);
    else chk(rtag(ri), ra_data, mrd(ri));
    if (op == 1 && !sp && a == rj) chk("R12", rb_data, d);
    else chk(rtag(rj), rb_data, mrd(rj));
    chk("R8", 64'(spill_req), 64'(sp));
    chk("R9", 64'(fill_req), 64'(fl));
    @(posedge clk); #1;
    mstep(op, a, d, 1'b1, sp, fl);
    case (op)
      1: t = "R4"; 2: t = "R6"; 3: t = "R7"; 4, 5: t = "R11"; default: t = "R1";
    endcase
    chk(t, 64'(l_val), 64'(mL));
    chk(t, 64'(g_val), 64'(mG));
    chk(t, 64'(win_base), 64'(mbase));
  endtask

  function automatic int pick_idx();
    if ($urandom % 2 == 0) return ($urandom % (mL + 4)) % 256;
    return 200 + ($urandom % 56);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int op, a, r;
    void'($urandom(32'd7));
    mL = 0; mG = 255; mbase = 0;
    for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
    for (int i = 0; i < 256; i++) mgv[i] = 1'b0;
    rst_n = 1'b0;
    we = 0; push = 0; pop = 0; l_we = 0; g_we = 0;
    ra_idx = 0; rb_idx = 0; wa_idx = 0; wd = 0; push_cnt = 0; l_wdata = 0; g_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cycle(0, 0, 0, 0, 255);                         // R1 reset state
    cycle(1, 5, 64'hA5A5_0000_1111_0005, 5, 3);     // R4 growth, R12 bypass, R3
    cycle(0, 0, 0, 3, 5);                           // R10 fresh, R2
    cycle(1, 3, 64'hB0B0_0000_0000_0003, 3, 200);
    cycle(1, 1, 64'hE1E1_0000_0000_0001, 1, 3);
    cycle(1, 200, 64'hC2C2_0000_0000_00C8, 200, 1); // R5 global write
    cycle(4, 10, 0, 8, 3);                          // R11 L write grows
    cycle(0, 0, 0, 8, 9);                           // R10
    cycle(2, 2, 0, 0, 200);                         // R6 push
    cycle(0, 0, 0, 0, 200);                         // R6 callee reg0 = caller reg3
    cycle(1, 0, 64'hD3D3_0000_0000_0000, 0, 6);
    cycle(3, 0, 0, 1, 3);                           // R7 pop
    cycle(0, 0, 0, 1, 200);                         // R7 restored, R5 untouched
    cycle(3, 0, 0, 0, 1);                           // R9 pop at base 0
    cycle(5, 10, 0, 40, 1);                         // R11 G floor
    cycle(4, 100, 0, 33, 31);                       // R11 L clamped to G
    cycle(5, 255, 0, 0, 1);
    cycle(4, 255, 0, 254, 0);
    cycle(2, 254, 0, 0, 0);
    cycle(2, 254, 0, 0, 0);
    cycle(4, 3, 0, 2, 0);                           // R8 L growth overflow
    cycle(1, 2, 64'h1, 2, 1);                       // R8 marginal write overflow
    cycle(1, 1, 64'h2, 1, 0);
    cycle(2, 0, 0, 0, 0);
    cycle(2, 0, 0, 0, 0);
    cycle(2, 0, 0, 0, 0);                           // R8 push overflow
    repeat (6) cycle(3, 0, 0, 0, 1);
    for (int n = 0; n < 5000; n++) begin
      r = $urandom % 16;
      if (r < 6)       begin op = 1; a = pick_idx(); end
      else if (r < 9)  begin op = 2; a = ($urandom % (mL + 3)) % 256; end
      else if (r < 12) begin op = 3; a = 0; end
      else if (r < 14) begin op = 4; a = ($urandom % (mL + 8)) % 256; end
      else if (r == 14 && ($urandom % 4 == 0)) begin op = 5; a = $urandom % 256; end
      else             begin op = 0; a = 0; end
      cycle(op, a, {$urandom, $urandom}, pick_idx(), pick_idx());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule